// File: doc/BRIEF.md
# Gap-Width Pulse Modulator with Calibration Preamble

This block is the sending side of a link in which each bit is marked by a short interruption of an RF carrier. It runs from a fixed system clock and drives a single carrier-enable line. The line is high while the carrier should be on and low during a gap. Every bit occupies one fixed bit interval. The interval opens with a gap whose length tells the receiver the bit value: a short gap is a zero and a long gap is a one. The carrier stays on for the rest of the interval.

A transmission starts with a fixed calibration header. The header is three long gaps followed by one calibration gap, which is somewhat longer than a long gap. The receiver measures the calibration gap with its own uncalibrated oscillator and derives its decision threshold from it. The data bits follow the header, most significant bit first.

A user offers a word and a bit count with a start request while the block is ready. The block latches both and sends the whole frame. It becomes ready again after the final bit interval. All durations are parameters counted in system clock cycles. The defaults assume 100 MHz: 40 cycles for a zero gap, 100 for a one gap, 130 for the calibration gap and 700 for the bit interval. With these values the long gap stays well below a fifth of the bit interval.

Top module: `gapmod_tx`

## Requirements
- R1: While no frame is in progress (including directly after reset), ready_o is 1 and carrier_en_o is 1.
- R2: A start_i sampled high on a rising edge while ready_o is 1 starts a frame. ready_o is 0 from the next cycle on, and carrier_en_o goes low in that same next cycle.
- R3: A start_i asserted while a frame is in progress is ignored: the frame's waveform and length are unchanged.
- R4: Every bit interval is BIT_PERIOD cycles long. carrier_en_o is 0 for exactly the gap width of that interval, starting at the interval's first cycle, and then 1 for the remaining cycles.
- R5: The first three intervals of every frame carry a gap of ONE_GAP cycles.
- R6: The fourth interval carries a gap of CAL_GAP cycles.
- R7: Data intervals follow, sending data_i[n-1] down to data_i[0]. A 1 bit gets a gap of ONE_GAP cycles and a 0 bit a gap of ZERO_GAP cycles.
- R8: A frame keeps ready_o at 0 for exactly (4+n)*BIT_PERIOD cycles. ready_o is still 0 in the last cycle of the last interval and is 1 in the cycle after it.
- R9: Here n is nbits_i as sampled at start, capped at MAX_BITS. With n = 0 the frame consists of the header only.
- R10: Changes on data_i and nbits_i during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, honoured only while ready_o is 1 |
| ready_o | output | 1 | High when a new frame may be started |
| data_i | input | MAX_BITS | Data word, sampled at start |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of data bits to send, sampled at start |
| carrier_en_o | output | 1 | Carrier enable, low during a gap |

## Verification
The bench sweeps every data pattern for every bit count from zero to the maximum, on a small configuration. For each interval it checks the exact low-then-high shape cycle by cycle. A design that sent bits LSB first, or aligned a short word to the wrong end of the register, would show the wrong gap widths in the data intervals. A design that was off by one in the interval counter would show its error in the shape of the interval. A zero bit count and a count above the maximum are both driven. Getting these wrong would add a spurious data interval or drop real bits. The bench also raises start and changes the data and count in the middle of a frame. A design that re-latched its inputs or restarted its header would then produce a different waveform or a frame of the wrong length.

// File: rtl/gapmod_pkg.sv
package gapmod_pkg;
  // Frame segment currently being sent
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_PRE  = 2'd1,
    SEG_CAL  = 2'd2,
    SEG_DATA = 2'd3
  } seg_e;
endpackage

// File: rtl/gapmod_timer.sv
module gapmod_timer #(
  parameter int BIT_PERIOD = 700,
  localparam int CNT_W = $clog2(BIT_PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cyc_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(BIT_PERIOD - 1);

  logic [CNT_W-1:0] cyc_q, cyc_d;

  assign last_o = run_i && (cyc_q == LAST_CYC);
  assign cyc_o  = cyc_q;

  always_comb begin
    cyc_d = cyc_q;
    if (clr_i) begin
      cyc_d = '0;
    end else if (run_i) begin
      cyc_d = (cyc_q == LAST_CYC) ? '0 : cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (clr_i || run_i) begin
      cyc_q <= cyc_d;
    end
  end
endmodule

// File: rtl/gapmod_shifter.sv
module gapmod_shifter #(
  parameter int MAX_BITS = 32,
  localparam int NB_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [NB_W-1:0]     nbits_i,
  input  logic                shift_i,
  output logic                msb_o,
  output logic [NB_W-1:0]     left_o
);
  localparam logic [NB_W-1:0] MAX_NB = NB_W'(MAX_BITS);

  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic [NB_W-1:0]     left_q, left_d;
  logic [NB_W-1:0]     nb_cap;

  // Cap the requested count at the word width
  assign nb_cap = (nbits_i > MAX_NB) ? MAX_NB : nbits_i;
  assign msb_o  = sh_q[MAX_BITS-1];
  assign left_o = left_q;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load_i) begin
      // Move the first bit to send to the top of the register
      sh_d   = data_i << (MAX_NB - nb_cap);
      left_d = nb_cap;
    end else if (shift_i) begin
      sh_d   = sh_q << 1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i || shift_i) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/gapmod_seq.sv
module gapmod_seq
  import gapmod_pkg::*;
#(
  parameter int PRE_N = 3,
  parameter int NB_W  = 6,
  localparam int PC_W = $clog2(PRE_N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            last_i,
  input  logic [NB_W-1:0] left_i,
  output seg_e            seg_o,
  output logic            accept_o,
  output logic            shift_o,
  output logic            busy_o
);
  localparam logic [PC_W-1:0] PRE_LAST = PC_W'(PRE_N - 1);
  localparam logic [NB_W-1:0] ONE_LEFT = NB_W'(1);

  seg_e            seg_q, seg_d;
  logic [PC_W-1:0] pre_q, pre_d;

  assign busy_o   = (seg_q != SEG_IDLE);
  assign accept_o = start_i && (seg_q == SEG_IDLE);
  assign seg_o    = seg_q;

  always_comb begin
    seg_d   = seg_q;
    pre_d   = pre_q;
    shift_o = 1'b0;
    unique case (seg_q)
      SEG_IDLE: begin
        if (start_i) begin
          seg_d = SEG_PRE;
          pre_d = '0;
        end
      end
      SEG_PRE: begin
        if (last_i) begin
          if (pre_q == PRE_LAST) seg_d = SEG_CAL;
          else                   pre_d = pre_q + 1'b1;
        end
      end
      SEG_CAL: begin
        if (last_i) seg_d = (left_i == '0) ? SEG_IDLE : SEG_DATA;
      end
      SEG_DATA: begin
        if (last_i) begin
          shift_o = 1'b1;
          if (left_i == ONE_LEFT) seg_d = SEG_IDLE;
        end
      end
      default: seg_d = SEG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_IDLE;
      pre_q <= '0;
    end else begin
      seg_q <= seg_d;
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/gapmod_tx.sv
module gapmod_tx
  import gapmod_pkg::*;
#(
  parameter int ZERO_GAP   = 40,
  parameter int ONE_GAP    = 100,
  parameter int CAL_GAP    = 130,
  parameter int BIT_PERIOD = 700,
  parameter int PRE_N      = 3,
  parameter int MAX_BITS   = 32,
  localparam int NB_W  = $clog2(MAX_BITS + 1),
  localparam int CNT_W = $clog2(BIT_PERIOD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                ready_o,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [NB_W-1:0]     nbits_i,
  output logic                carrier_en_o
);
  localparam logic [CNT_W-1:0] W_ZERO = CNT_W'(ZERO_GAP);
  localparam logic [CNT_W-1:0] W_ONE  = CNT_W'(ONE_GAP);
  localparam logic [CNT_W-1:0] W_CAL  = CNT_W'(CAL_GAP);

  seg_e             seg;
  logic             accept, shift, busy, last, msb;
  logic [NB_W-1:0]  left;
  logic [CNT_W-1:0] cyc, width;

  gapmod_seq #(.PRE_N(PRE_N), .NB_W(NB_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last),
    .left_i(left), .seg_o(seg), .accept_o(accept), .shift_o(shift),
    .busy_o(busy)
  );

  gapmod_timer #(.BIT_PERIOD(BIT_PERIOD)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .run_i(busy),
    .cyc_o(cyc), .last_o(last)
  );

  gapmod_shifter #(.MAX_BITS(MAX_BITS)) shifter_i (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .data_i(data_i),
    .nbits_i(nbits_i), .shift_i(shift), .msb_o(msb), .left_o(left)
  );

  // Gap width of the interval now being sent
  always_comb begin
    unique case (seg)
      SEG_PRE:  width = W_ONE;
      SEG_CAL:  width = W_CAL;
      SEG_DATA: width = msb ? W_ONE : W_ZERO;
      default:  width = '0;
    endcase
  end

  assign ready_o      = ~busy;
  assign carrier_en_o = ~(busy && (cyc < width));
endmodule

// File: rtl/gapmod_tx_chk.sv
module gapmod_tx_chk #(
  parameter int ZERO_GAP   = 40,
  parameter int ONE_GAP    = 100,
  parameter int CAL_GAP    = 130,
  parameter int BIT_PERIOD = 700,
  parameter int PRE_N      = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ready_o,
  input logic carrier_en_o
);
  logic [31:0] low_run_q, busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= '0;
      busy_run_q <= '0;
    end else begin
      low_run_q  <= carrier_en_o ? 32'd0 : low_run_q + 32'd1;
      busy_run_q <= ready_o ? 32'd0 : busy_run_q + 32'd1;
    end
  end

  // R1
  idle_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> carrier_en_o);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> (!ready_o && !carrier_en_o));

  // R4
  gap_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_en_o && low_run_q != 0) |->
      (low_run_q == ZERO_GAP || low_run_q == ONE_GAP || low_run_q == CAL_GAP));

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && busy_run_q != 0) |->
      ((busy_run_q % BIT_PERIOD) == 0 && busy_run_q >= (PRE_N + 1) * BIT_PERIOD));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && busy_run_q < (PRE_N + 1) * BIT_PERIOD - 1) |=> !ready_o);
endmodule

bind gapmod_tx gapmod_tx_chk #(
  .ZERO_GAP(ZERO_GAP), .ONE_GAP(ONE_GAP), .CAL_GAP(CAL_GAP),
  .BIT_PERIOD(BIT_PERIOD), .PRE_N(PRE_N)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .carrier_en_o(carrier_en_o)
);

// File: tb/gapmod_tx_tb.sv
module gapmod_tx_tb_top;
  localparam int ZG  = 4;
  localparam int OG  = 10;
  localparam int CG  = 13;
  localparam int BP  = 70;
  localparam int MB  = 6;
  localparam int NBW = $clog2(MB + 1);

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [MB-1:0]  data;
  logic [NBW-1:0] nbits;
  logic           ready;
  logic           carrier;

  int checks;
  int fails;
  bit finished;

  gapmod_tx #(
    .ZERO_GAP(ZG), .ONE_GAP(OG), .CAL_GAP(CG), .BIT_PERIOD(BP),
    .PRE_N(3), .MAX_BITS(MB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ready_o(ready),
    .data_i(data), .nbits_i(nbits), .carrier_en_o(carrier)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Send one frame and compare every cycle against the computed waveform.
  task automatic run_tx(input logic [MB-1:0] d, input int nb, input bit disturb);
    int neff  = (nb > MB) ? MB : nb;
    int total = 4 + neff;
    @(negedge clk);
    start = 1'b1;
    data  = d;
    nbits = NBW'(nb);
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R2", "ready after start", int'(ready), 0);
    for (int k = 0; k < total; k++) begin
      int    w;
      int    bad = -1;
      int    lowcnt = 0;
      string req;
      if (k < 3) begin
        w = OG; req = "R4 R5";
      end else if (k == 3) begin
        w = CG; req = "R4 R6";
      end else begin
        w   = d[neff - 1 - (k - 4)] ? OG : ZG;
        req = (nb > MB) ? "R7 R9 clamp" : "R4 R7";
      end
      if (disturb) req = "R3 R10 disturbed";
      for (int c = 0; c < BP; c++) begin
        if (disturb && k == 1 && c == 20) begin
          start = 1'b1;
          data  = ~d;
          nbits = NBW'(MB);
        end
        if (disturb && k == 1 && c == 25) start = 1'b0;
        if (!carrier) lowcnt++;
        if ((carrier == 1'b1) != (c >= w) && bad < 0) bad = c;
        if (k == total - 1 && c == BP - 1)
          check(ready == 1'b0, "R8", "ready in last cycle", int'(ready), 0);
        @(negedge clk);
      end
      check(bad < 0, req, $sformatf("interval %0d low cycles", k), lowcnt, w);
    end
    check(ready == 1'b1, (nb == 0) ? "R8 R9 header only" : "R8",
          "ready after frame", int'(ready), 1);
    check(carrier == 1'b1, "R1", "carrier after frame", int'(carrier), 1);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    start = 1'b0; data = '0; nbits = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1", "ready in reset", int'(ready), 1);
    check(carrier == 1'b1, "R1", "carrier in reset", int'(carrier), 1);
    rst_n = 1'b1;
    begin
      int lows = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!carrier || !ready) lows++;
      end
      check(lows == 0, "R1", "idle cycles with carrier off", lows, 0);
    end
    // Every pattern for every bit count
    for (int n = 0; n <= MB; n++) begin
      for (int v = 0; v < (1 << n); v++) begin
        run_tx(MB'(v), n, 1'b0);
      end
    end
    // Count above the maximum is capped
    run_tx(6'b101101, MB + 1, 1'b0);
    run_tx(6'b010011, MB + 1, 1'b0);
    // Start and input changes while busy
    run_tx(6'b100110, 4, 1'b1);
    run_tx(6'b000001, 2, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule